// File: doc/BRIEF.md
# Programmable Counter Array with Watchdog

This block is a timer array built around one shared 16-bit count register. The count register advances on a single-cycle enable. That enable comes from one of seven timebases, all taken in the system clock domain: every cycle, a divide-by-4 or divide-by-12 prescale of the clock, an eighth of the external-oscillator ticks, an eighth of the real-time ticks, a synchronized timer-0 overflow strobe, or a synchronized external count pin. The count register feeds six capture/compare units. Software can place each unit in a different mode: pin-edge capture, software timer, toggle-on-match output, frequency output, 8-bit PWM or 16-bit PWM.

The last unit can also serve as a watchdog, and it comes out of reset in that role. While the watchdog is on, it keeps the count register advancing whatever the run bit says, and software cannot load the count. If the count steps onto that unit's compare value, the block raises a sticky reset request. Software holds the watchdog off by rewriting the compare value ahead of the count, or turns it off with a write. All configuration goes through a single-cycle write port and a combinational read port.

Top module: `pca_array`

## Requirements
- R1: After reset these values hold: count 0, run 0, timebase 0, all flags 0, all output pins 0, every unit in mode 0 with compare 0, watchdog enabled (address 3 reads 1), and the last unit's compare at 16'hFFFF.
- R2: Address 0 holds run in bit 0 and the timebase in bits 3:1. The timebase codes are: 0 every cycle, 1 one cycle in 4, 2 one cycle in 12, 3 every 8th `osc_tick`, 4 every 8th `rtc_tick`, 5 timer-0 strobe, 6 external pin, 7 never. The count advances by one on a timebase tick only while run is 1 or the watchdog is enabled. A write to address 1 loads the count.
- R3: A unit in mode 1 copies the count into its compare register and sets its flag on a synchronized rising edge of its capture pin (config bit 3 set), a falling edge (config bit 4 set), or both.
- R4: In mode 2 a unit sets its flag on the cycle the count steps onto its compare value.
- R5: In mode 3 a unit sets its flag and inverts its output pin on the cycle the count steps onto its compare value.
- R6: In mode 4 a unit sets its flag and inverts its pin whenever the count's low byte steps onto the compare low byte. The compare low byte then grows by the compare high byte.
- R7: In mode 5 a unit drives its pin high while the count low byte is below the compare low byte. When the low byte wraps from 8'hFF, the compare low byte is reloaded from the compare high byte.
- R8: In mode 6 a unit drives its pin high while the count is below the compare value.
- R9: While the watchdog is enabled, the count steps onto the last unit's compare value, the unit's mode is ignored, and writes to the count have no effect. When that happens, `wdt_rst_req` rises and stays high until reset. Writing 0 to bit 0 of address 3 disables the watchdog, and address 3 reads {request, enable}.
- R10: Writing to address 2 clears each flag whose data bit is 1. A flag set in the same cycle survives the clear.
- R11: The capture, timer-0 and external pins pass through a two-stage synchronizer. One pin edge produces at most one count step or one capture.
- R12: Unit m has its configuration at address 8+2m and its compare register at address 9+2m. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data, combinational |
| osc_tick | input | 1 | External-oscillator enable pulse |
| rtc_tick | input | 1 | Real-time enable pulse |
| t0_strobe | input | 1 | Timer-0 overflow level, asynchronous |
| ext_pin | input | 1 | External count pin, asynchronous |
| cap_pin | input | 6 | Per-unit capture pins, asynchronous |
| unit_out | output | 6 | Per-unit output pins |
| irq_flag | output | 6 | Per-unit event flags |
| wdt_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The assertions assume that the bus writes one register per cycle. They also assume that the count moves only through a load or a single-step advance. The bench meets both, since it issues one write at a time and never asks for two advances in one cycle. The synchronizers reset to 0, so a pin that sits high across reset would read as a rising edge. The stimulus therefore holds every asynchronous pin low while reset is asserted, and it changes pins only half a cycle away from the active edge. Pin activity is random, but it stays slow enough that each edge lasts at least one cycle.

// File: rtl/pca_pkg.sv
package pca_pkg;
   typedef enum logic [2:0] {
      MD_IDLE = 3'd0, MD_CAPT = 3'd1, MD_TIMER = 3'd2, MD_TOGGLE = 3'd3,
      MD_FREQ = 3'd4, MD_PWM8 = 3'd5, MD_PWM16 = 3'd6, MD_SPARE = 3'd7
   } unit_mode_e;

   typedef enum logic [2:0] {
      TB_SYS = 3'd0, TB_DIVA = 3'd1, TB_DIVB = 3'd2, TB_OSC = 3'd3,
      TB_RTC = 3'd4, TB_T0 = 3'd5, TB_PIN = 3'd6, TB_NONE = 3'd7
   } tb_src_e;

   typedef struct packed {
      logic       cap_fall;
      logic       cap_rise;
      unit_mode_e mode;
   } unit_cfg_t;

   localparam int unsigned A_CTRL = 0;
   localparam int unsigned A_COUNT = 1;
   localparam int unsigned A_FLAGS = 2;
   localparam int unsigned A_WDOG = 3;
   localparam int unsigned A_UNIT_BASE = 8;
   localparam int unsigned LOW_W = 8;
endpackage

// File: rtl/pca_edge_sync.sv
module pca_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic prv
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pca_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign lvl = sh_q[STAGES-1];
   assign prv = sh_q[STAGES];
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
   import pca_pkg::*;
#(
   parameter int unsigned DIV_A = 4,
   parameter int unsigned DIV_B = 12,
   parameter int unsigned DIV_X = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  tb_src_e src,
   input  logic    osc_tick,
   input  logic    rtc_tick,
   input  logic    t0_strobe,
   input  logic    ext_pin,
   output logic    tick
);
   if (DIV_A < 2 || DIV_B < 2 || DIV_X < 2) begin : g_bad_div
      $error("pca_timebase: every divider must be at least 2");
   end

   localparam int unsigned WA = $clog2(DIV_A);
   localparam int unsigned WB = $clog2(DIV_B);
   localparam int unsigned WX = $clog2(DIV_X);

   logic [WA-1:0] pa_q;
   logic [WB-1:0] pb_q;
   logic [WX-1:0] po_q, pr_q;
   logic t0_lvl, t0_prv, ep_lvl, ep_prv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_q <= '0;
         pb_q <= '0;
         po_q <= '0;
         pr_q <= '0;
      end else begin
         pa_q <= (pa_q == WA'(DIV_A - 1)) ? '0 : pa_q + 1'b1;
         pb_q <= (pb_q == WB'(DIV_B - 1)) ? '0 : pb_q + 1'b1;
         if (osc_tick) po_q <= (po_q == WX'(DIV_X - 1)) ? '0 : po_q + 1'b1;
         if (rtc_tick) pr_q <= (pr_q == WX'(DIV_X - 1)) ? '0 : pr_q + 1'b1;
      end
   end

   pca_edge_sync #(.STAGES(SYNC_STAGES)) u_t0_sync (
      .clk(clk), .rst_n(rst_n), .din(t0_strobe), .lvl(t0_lvl), .prv(t0_prv));
   pca_edge_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_pin), .lvl(ep_lvl), .prv(ep_prv));

   always_comb begin
      unique case (src)
         TB_SYS:  tick = 1'b1;
         TB_DIVA: tick = (pa_q == WA'(DIV_A - 1));
         TB_DIVB: tick = (pb_q == WB'(DIV_B - 1));
         TB_OSC:  tick = osc_tick && (po_q == WX'(DIV_X - 1));
         TB_RTC:  tick = rtc_tick && (pr_q == WX'(DIV_X - 1));
         TB_T0:   tick = t0_lvl && !t0_prv;
         TB_PIN:  tick = ep_lvl && !ep_prv;
         default: tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/pca_unit.sv
module pca_unit
   import pca_pkg::*;
#(
   parameter int unsigned CW = 16,
   parameter bit          IS_WDT = 1'b0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cfg,
   input  logic          wr_cmp,
   input  logic [CW-1:0] wr_data,
   input  logic          adv,
   input  logic [CW-1:0] cnt_q,
   input  logic [CW-1:0] cnt_nxt,
   input  logic          cap_pin,
   input  logic          wdt_en,
   output unit_cfg_t     cfg_q,
   output logic [CW-1:0] cmp_q,
   output logic          pin_out,
   output logic          evt,
   output logic          wdt_hit
);
   if (CW < 2 * LOW_W) begin : g_bad_cw
      $error("pca_unit: CW must hold two low-byte fields");
   end

   localparam logic [CW-1:0] CMP_RST = IS_WDT ? '1 : '0;

   unit_mode_e mode_eff;
   logic cap_lvl, cap_prv, cap_hit, full_hit, lo_hit, lo_wrap, tog_q;
   logic [LOW_W-1:0] step;

   pca_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_pin), .lvl(cap_lvl), .prv(cap_prv));

   assign mode_eff = (IS_WDT && wdt_en) ? MD_IDLE : cfg_q.mode;
   assign cap_hit  = (cap_lvl && !cap_prv && cfg_q.cap_rise) ||
                     (!cap_lvl && cap_prv && cfg_q.cap_fall);
   assign full_hit = adv && (cnt_nxt == cmp_q);
   assign lo_hit   = adv && (cnt_nxt[LOW_W-1:0] == cmp_q[LOW_W-1:0]);
   assign lo_wrap  = adv && (cnt_q[LOW_W-1:0] == '1);
   assign step     = cmp_q[2*LOW_W-1:LOW_W];

   always_comb begin
      unique case (mode_eff)
         MD_CAPT:            evt = cap_hit;
         MD_TIMER, MD_TOGGLE: evt = full_hit;
         MD_FREQ:            evt = lo_hit;
         default:            evt = 1'b0;
      endcase
   end

   always_comb begin
      unique case (mode_eff)
         MD_TOGGLE, MD_FREQ: pin_out = tog_q;
         MD_PWM8:  pin_out = (cnt_q[LOW_W-1:0] < cmp_q[LOW_W-1:0]);
         MD_PWM16: pin_out = (cnt_q < cmp_q);
         default:  pin_out = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         cmp_q <= CMP_RST;
         tog_q <= 1'b0;
      end else begin
         if (wr_cfg) cfg_q <= unit_cfg_t'(wr_data[$bits(unit_cfg_t)-1:0]);
         if (wr_cmp) cmp_q <= wr_data;
         else if (mode_eff == MD_CAPT && cap_hit) cmp_q <= cnt_q;
         else if (mode_eff == MD_FREQ && lo_hit)
            cmp_q[LOW_W-1:0] <= cmp_q[LOW_W-1:0] + step;
         else if (mode_eff == MD_PWM8 && lo_wrap) cmp_q[LOW_W-1:0] <= step;
         if ((mode_eff == MD_TOGGLE && full_hit) || (mode_eff == MD_FREQ && lo_hit))
            tog_q <= !tog_q;
      end
   end

   if (IS_WDT) begin : g_wdt
      assign wdt_hit = wdt_en && full_hit;
   end else begin : g_plain
      assign wdt_hit = 1'b0;
   end
endmodule

// File: rtl/pca_array.sv
module pca_array
   import pca_pkg::*;
#(
   parameter int unsigned NUM_UNIT = 6,
   parameter int unsigned CW = 16,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_WDT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [CW-1:0]       wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [CW-1:0]       rd_data,
   input  logic                osc_tick,
   input  logic                rtc_tick,
   input  logic                t0_strobe,
   input  logic                ext_pin,
   input  logic [NUM_UNIT-1:0] cap_pin,
   output logic [NUM_UNIT-1:0] unit_out,
   output logic [NUM_UNIT-1:0] irq_flag,
   output logic                wdt_rst_req
);
   if (NUM_UNIT < 1 || NUM_UNIT > CW) begin : g_bad_units
      $error("pca_array: NUM_UNIT out of range");
   end
   if (A_UNIT_BASE + 2 * NUM_UNIT > (1 << ADDR_W)) begin : g_bad_addr
      $error("pca_array: ADDR_W too narrow for the unit registers");
   end

   logic                run_q, wen_q, tick, adv;
   tb_src_e             src_q;
   logic [CW-1:0]       cnt_q, cnt_nxt;
   logic [NUM_UNIT-1:0] evt, hit;
   unit_cfg_t           cfg_all [NUM_UNIT];
   logic [CW-1:0]       cmp_all [NUM_UNIT];

   function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned r);
      return a == ADDR_W'(r);
   endfunction

   pca_timebase #(.SYNC_STAGES(SYNC_STAGES)) u_tb (
      .clk(clk), .rst_n(rst_n), .src(src_q), .osc_tick(osc_tick),
      .rtc_tick(rtc_tick), .t0_strobe(t0_strobe), .ext_pin(ext_pin), .tick(tick));

   assign adv     = tick && (run_q || wen_q);
   assign cnt_nxt = cnt_q + CW'(adv);

   for (genvar u = 0; u < NUM_UNIT; u++) begin : g_unit
      pca_unit #(
         .CW(CW), .IS_WDT(HAS_WDT && (u == NUM_UNIT - 1)), .SYNC_STAGES(SYNC_STAGES)
      ) u_unit (
         .clk(clk), .rst_n(rst_n),
         .wr_cfg(wr_en && at(wr_addr, A_UNIT_BASE + 2 * u)),
         .wr_cmp(wr_en && at(wr_addr, A_UNIT_BASE + 2 * u + 1)),
         .wr_data(wr_data), .adv(adv), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
         .cap_pin(cap_pin[u]), .wdt_en(wen_q), .cfg_q(cfg_all[u]),
         .cmp_q(cmp_all[u]), .pin_out(unit_out[u]), .evt(evt[u]), .wdt_hit(hit[u]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         src_q       <= TB_SYS;
         cnt_q       <= '0;
         irq_flag    <= '0;
         wen_q       <= HAS_WDT;
         wdt_rst_req <= 1'b0;
      end else begin
         if (wr_en && at(wr_addr, A_CTRL)) begin
            run_q <= wr_data[0];
            src_q <= tb_src_e'(wr_data[3:1]);
         end
         if (wr_en && at(wr_addr, A_COUNT) && !wen_q) cnt_q <= wr_data;
         else                                          cnt_q <= cnt_nxt;
         irq_flag <= (irq_flag & ~((wr_en && at(wr_addr, A_FLAGS)) ?
                      wr_data[NUM_UNIT-1:0] : '0)) | evt;
         if (wr_en && at(wr_addr, A_WDOG)) wen_q <= HAS_WDT && wr_data[0];
         if (|hit) wdt_rst_req <= 1'b1;
      end
   end

   always_comb begin
      rd_data = '0;
      if (at(rd_addr, A_CTRL))  rd_data[3:0] = {src_q, run_q};
      if (at(rd_addr, A_COUNT)) rd_data = cnt_q;
      if (at(rd_addr, A_FLAGS)) rd_data[NUM_UNIT-1:0] = irq_flag;
      if (at(rd_addr, A_WDOG))  rd_data[1:0] = {wdt_rst_req, wen_q};
      for (int u = 0; u < NUM_UNIT; u++) begin
         if (at(rd_addr, A_UNIT_BASE + 2 * u))     rd_data[$bits(unit_cfg_t)-1:0] = cfg_all[u];
         if (at(rd_addr, A_UNIT_BASE + 2 * u + 1)) rd_data = cmp_all[u];
      end
   end
endmodule

// File: rtl/pca_array_chk.sv
module pca_array_chk #(
   parameter int unsigned CW = 16,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [CW-1:0]     cnt_q,
   input logic              run_q,
   input logic              wen_q,
   input logic              wdt_rst_req
);
   logic cnt_wr;
   assign cnt_wr = wr_en && (wr_addr == ADDR_W'(pca_pkg::A_COUNT));

   // R2: without a load the count holds or steps by exactly one
   p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) + 1'b1)));

   // R2: stopped with the watchdog off, the count is frozen
   p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wen_q && !cnt_wr) |=> $stable(cnt_q));

   // R9: loads are locked out while the watchdog runs
   p_cnt_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wen_q |=> (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) + 1'b1)));

   // R9: the request is sticky
   p_req_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |=> wdt_rst_req);

   // R9: a disabled watchdog never raises the request
   p_req_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wen_q && !wdt_rst_req) |=> !wdt_rst_req);
endmodule

bind pca_array pca_array_chk #(.CW(CW), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .cnt_q(cnt_q), .run_q(run_q), .wen_q(wen_q), .wdt_rst_req(wdt_rst_req));

// File: tb/pca_array_bench.sv
module pca_array_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        osc_tick = 1'b0, rtc_tick = 1'b0, t0_strobe = 1'b0, ext_pin = 1'b0;
   logic [5:0]  cap_pin = '0;
   logic [5:0]  unit_out, irq_flag;
   logic        wdt_rst_req;

   int    n_vec = 0, n_bad = 0;
   bit    noise = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   pca_array u_pca_array (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .osc_tick(osc_tick), .rtc_tick(rtc_tick),
      .t0_strobe(t0_strobe), .ext_pin(ext_pin), .cap_pin(cap_pin),
      .unit_out(unit_out), .irq_flag(irq_flag), .wdt_rst_req(wdt_rst_req));

   // behavioural reference state
   logic [15:0] m_cnt, m_cmp [6];
   logic [4:0]  m_cfg [6];
   logic [2:0]  m_cs [6];
   logic        m_tog [6];
   logic [2:0]  m_t0, m_ep, m_src;
   logic [5:0]  m_flag;
   logic        m_run, m_wen, m_wreq;
   int          m_p4, m_p12, m_po, m_pr;

   function automatic int mode_of(int u);
      if (u == 5 && m_wen) return 0;
      return int'(m_cfg[u][2:0]);
   endfunction

   function automatic logic [5:0] exp_out();
      logic [5:0] o = '0;
      for (int u = 0; u < 6; u++) begin
         case (mode_of(u))
            3, 4: o[u] = m_tog[u];
            5:    o[u] = (m_cnt[7:0] < m_cmp[u][7:0]);
            6:    o[u] = (m_cnt < m_cmp[u]);
            default: o[u] = 1'b0;
         endcase
      end
      return o;
   endfunction

   function automatic logic [15:0] exp_rd(int a);
      if (a == 0) return {12'd0, m_src, m_run};
      if (a == 1) return m_cnt;
      if (a == 2) return {10'd0, m_flag};
      if (a == 3) return {14'd0, m_wreq, m_wen};
      if (a >= 8 && a < 20) return (a % 2 == 0) ? {11'd0, m_cfg[(a-8)/2]} : m_cmp[(a-9)/2];
      return 16'd0;
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_run = 0; m_src = 0; m_wen = 1; m_wreq = 0; m_flag = 0;
      m_p4 = 0; m_p12 = 0; m_po = 0; m_pr = 0; m_t0 = 0; m_ep = 0;
      for (int u = 0; u < 6; u++) begin
         m_cmp[u] = (u == 5) ? 16'hFFFF : 16'h0000;
         m_cfg[u] = 0; m_cs[u] = 0; m_tog[u] = 0;
      end
   endtask

   task automatic model_step();
      logic tick, adv, rise, fall, caph, full, lo, wrap;
      logic [15:0] nxt, nc;
      logic [5:0] fset = '0;
      int md;
      case (m_src)
         0: tick = 1;
         1: tick = (m_p4 == 3);
         2: tick = (m_p12 == 11);
         3: tick = osc_tick && (m_po == 7);
         4: tick = rtc_tick && (m_pr == 7);
         5: tick = m_t0[1] && !m_t0[2];
         6: tick = m_ep[1] && !m_ep[2];
         default: tick = 0;
      endcase
      adv = tick && (m_run || m_wen);
      nxt = m_cnt + 16'(adv);
      for (int u = 0; u < 6; u++) begin
         md   = mode_of(u);
         rise = m_cs[u][1] && !m_cs[u][2];
         fall = !m_cs[u][1] && m_cs[u][2];
         caph = (rise && m_cfg[u][3]) || (fall && m_cfg[u][4]);
         full = adv && (nxt == m_cmp[u]);
         lo   = adv && (nxt[7:0] == m_cmp[u][7:0]);
         wrap = adv && (m_cnt[7:0] == 8'hFF);
         nc   = m_cmp[u];
         case (md)
            1: if (caph) begin fset[u] = 1; nc = m_cnt; end
            2: if (full) fset[u] = 1;
            3: if (full) begin fset[u] = 1; m_tog[u] = !m_tog[u]; end
            4: if (lo) begin
                  fset[u] = 1; m_tog[u] = !m_tog[u];
                  nc[7:0] = nc[7:0] + nc[15:8];
               end
            5: if (wrap) nc[7:0] = nc[15:8];
            default: ;
         endcase
         if (u == 5 && m_wen && full) m_wreq = 1;
         if (wr_en && wr_addr == 5'(9 + 2*u)) nc = wr_data;
         if (wr_en && wr_addr == 5'(8 + 2*u)) m_cfg[u] = wr_data[4:0];
         m_cmp[u] = nc;
         m_cs[u] = {m_cs[u][1:0], cap_pin[u]};
      end
      m_flag = (m_flag & ~((wr_en && wr_addr == 5'd2) ? wr_data[5:0] : 6'd0)) | fset;
      m_cnt = (wr_en && wr_addr == 5'd1 && !m_wen) ? wr_data : nxt;
      if (wr_en && wr_addr == 5'd0) begin m_run = wr_data[0]; m_src = wr_data[3:1]; end
      if (wr_en && wr_addr == 5'd3) m_wen = wr_data[0];
      m_p4 = (m_p4 + 1) % 4;
      m_p12 = (m_p12 + 1) % 12;
      if (osc_tick) m_po = (m_po + 1) % 8;
      if (rtc_tick) m_pr = (m_pr + 1) % 8;
      m_t0 = {m_t0[1:0], t0_strobe};
      m_ep = {m_ep[1:0], ext_pin};
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else        model_step();
   end

   task automatic check(string what, logic [15:0] act, logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual %h expected %h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("unit_out", 16'(unit_out), 16'(exp_out()));
         check("irq_flag", 16'(irq_flag), 16'(m_flag));
         check("wdt_rst_req R9", 16'(wdt_rst_req), 16'(m_wreq));
         check($sformatf("rd_data@%0d", rd_addr), rd_data, exp_rd(int'(rd_addr)));
      end
   end

   task automatic run(int n);
      repeat (n) begin
         @(negedge clk); #1;
         if (noise) begin
            if ($urandom % 4 == 0) cap_pin = cap_pin ^ 6'($urandom);
            osc_tick = 1'($urandom % 2);
            rtc_tick = ($urandom % 3 == 0);
            if ($urandom % 4 == 0) t0_strobe = !t0_strobe;
            if ($urandom % 3 == 0) ext_pin = !ext_pin;
         end
      end
   endtask

   task automatic wr(int a, logic [15:0] d);
      @(negedge clk); #1;
      wr_en = 1; wr_addr = 5'(a); wr_data = d;
      @(negedge clk); #1;
      wr_en = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); #1;
      rst_n = 0; noise = 0;
      cap_pin = '0; t0_strobe = 0; ext_pin = 0; osc_tick = 0; rtc_tick = 0;
      run(3);
      rst_n = 1;
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog expired: actual still running, expected finished");
      finish_run();
   end

   initial begin
      // R1: reset values seen through every register
      cur_req = "R1";
      run(3);
      rst_n = 1;
      for (int a = 0; a < 21; a++) begin rd_addr = 5'(a); run(1); end

      // R9: watchdog from reset; count load is ignored, service, then expiry
      cur_req = "R9";
      rd_addr = 5'd1;
      wr(1, 16'd5);
      wr(19, 16'd200);
      run(60);
      wr(19, 16'd400);
      rd_addr = 5'd3;
      run(420);
      run(20);
      do_reset();
      wr(3, 16'd0);
      rd_addr = 5'd1;
      run(30);

      // R2: each internal timebase, plus stop and the null code
      cur_req = "R2";
      noise = 1;
      for (int s = 0; s < 5; s++) begin
         wr(0, 16'((s << 1) | 1));
         run(80);
      end
      wr(0, 16'((7 << 1) | 1));
      run(20);
      wr(0, 16'd0);
      wr(1, 16'h1234);
      run(20);

      // R11: synchronized strobe and pin sources
      cur_req = "R11";
      wr(0, 16'((5 << 1) | 1));
      run(120);
      wr(0, 16'((6 << 1) | 1));
      run(120);

      // R3 R4 R5 R6 R7 together on the fast timebase
      cur_req = "R3/R4/R5/R6/R7/R12";
      wr(0, 16'd0);
      wr(1, 16'd0);
      wr(8, 16'b01001);  wr(10, 16'b11001);
      wr(12, 16'd2);     wr(13, 16'd100);
      wr(14, 16'd3);     wr(15, 16'd50);
      wr(16, 16'd4);     wr(17, 16'h070A);
      wr(18, 16'd5);     wr(19, 16'h3C14);
      wr(0, 16'd1);
      for (int k = 0; k < 6; k++) begin
         rd_addr = 5'(9 + 2*k);
         run(60);
      end
      rd_addr = 5'd19;
      wr(19, 16'h8014);
      run(300);

      // R10: write-one clear while events keep arriving
      cur_req = "R10";
      rd_addr = 5'd2;
      for (int k = 0; k < 8; k++) begin
         wr(2, 16'(k % 2 == 0 ? 6'h3F : 6'h15));
         run(25);
      end

      // R8: full-width PWM crossing its compare point
      cur_req = "R8";
      wr(12, 16'd6); wr(13, 16'h0180);
      wr(14, 16'd6); wr(15, 16'h0000);
      wr(16, 16'd6); wr(17, 16'hFFFF);
      wr(8, 16'd0);
      wr(1, 16'h0100);
      rd_addr = 5'd1;
      run(300);
      wr(1, 16'hFFF0);
      run(40);

      noise = 0;
      run(5);
      finish_run();
   end
endmodule